// File: doc/BRIEF.md
# Duplicated Data Array with Parity Repair

This block is the data storage of a cache level that must serve two loads in every cycle. The data is held in two identical copies, and each copy has its own read port: copy 0 serves load port 0 and copy 1 serves load port 1. Stores come in through a single port. Each store writes the same bytes into both copies, and a store blocks both load ports for the cycle in which it is accepted. Every byte is held together with an even parity bit. A store that writes only some bytes therefore recomputes only their parity and never has to read the word first.

When a load finds a parity error in the word read from its own copy, the response for that load is held back for one cycle. In that cycle the word is read again from the other copy. If the second read is good, it is returned on the next cycle and also written over the damaged word. If the second read also fails parity, the response carries an uncorrectable flag and nothing is written. The detection cycle and the repair cycle both block loads and stores. A test input flips one stored bit in a chosen copy so that these paths can be reached.

Load requests and stores use valid/ready handshakes. A transfer happens on a clock edge where valid and ready are both high. The requester holds its request until it sees ready, and ready never depends on the load's own valid. Responses have no back-pressure: they appear for exactly one cycle and must be taken in that cycle.

Top module: `dual_copy_array`

## Requirements
- R1: After reset every word of both copies reads as zero with good parity, no response is valid, and `st_ready` and both `ld_ready` are high.
- R2: A load accepted at a clock edge whose word has good parity gives `rsp_valid` with the data in the following cycle. The two ports work independently in the same cycle.
- R3: An accepted store writes the bytes of `st_data` whose `st_be` bit is set (bit b covers data bits 8b+7..8b) into both copies, and leaves the other bytes of that word unchanged.
- R4: In a cycle where a store is accepted, both `ld_ready` outputs are low.
- R5: If a load's word fails parity in its own copy, `rsp_valid` stays low in the cycle after acceptance. In the next cycle the response is valid, carries the data from the other copy, and `corr_evt` pulses on that port.
- R6: After a repair, a later load of the same word on the same port returns with the normal latency of one cycle and without `corr_evt`.
- R7: In the cycle an error is detected and in the repair cycle that follows, `st_ready` and both `ld_ready` are low.
- R8: If both copies fail parity on the same word, the delayed response is valid with `rsp_uerr` high and `corr_evt` low. Neither copy is rewritten, so a later load of that word reports `rsp_uerr` again.
- R9: `inj_valid` inverts stored bit `inj_bit` of word `inj_addr` in copy `inj_copy`. Within the stored word, byte b occupies bits 9b..9b+7 and its parity bit is bit 9b+8. Inverting only a parity bit still goes through the repair path, and the data returned is unchanged.
- R10: If both ports detect an error in the same cycle, both are repaired in the same repair cycle. Each port reads the other copy and writes its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 2 | Load request valid, one bit per port |
| ld_ready | output | 2 | Load request ready, one bit per port |
| ld_addr | input | 2*AW | Load word addresses, port p in bits p*AW +: AW |
| st_valid | input | 1 | Store valid |
| st_ready | output | 1 | Store ready |
| st_addr | input | AW | Store word address |
| st_be | input | BYTES | Store byte enables |
| st_data | input | 8*BYTES | Store data |
| inj_valid | input | 1 | Test: flip one stored bit |
| inj_copy | input | 1 | Test: copy to be disturbed |
| inj_addr | input | AW | Test: word to be disturbed |
| inj_bit | input | IW | Test: bit index within the stored word |
| rsp_valid | output | 2 | Load response valid, one per port |
| rsp_data | output | 2*8*BYTES | Response data, port p in bits p*8*BYTES +: 8*BYTES |
| rsp_uerr | output | 2 | Response data unusable: both copies failed parity |
| corr_evt | output | 2 | One-cycle pulse: a response was corrected from the other copy |

## Verification
The hardest case to reach from the ports is two errors at once. One variant is an error in both copies of a single word. The other is errors on both ports in the same detection cycle, where each port's repair must read the copy the other port is writing. Correct behaviour on the ports cannot produce either case, so the stimulus uses the bit-flip input. For the first variant it flips bits in both copies of one word, and for the second it damages copy 0 at one address and copy 1 at another, then issues the two loads together. A random phase mixes stores, paired loads and occasional flips. It is compared every cycle against a model that holds both copies, which also covers a store that arrives while a repair is in progress.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  localparam int unsigned SLICE_W = 9;  // 8 data bits plus parity

  function automatic logic even_par(input logic [7:0] b);
    return ^b;
  endfunction
endpackage

// File: rtl/dcc_bank.sv
module dcc_bank #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned BYTES = 4,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter int unsigned WW    = BYTES * dcc_pkg::SLICE_W,
  parameter int unsigned IW    = $clog2(WW)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               st_en,
  input  logic [AW-1:0]      st_addr,
  input  logic [BYTES-1:0]   st_be,
  input  logic [8*BYTES-1:0] st_data,
  input  logic               fx_en,
  input  logic [AW-1:0]      fx_addr,
  input  logic [WW-1:0]      fx_word,
  input  logic               inj_en,
  input  logic [AW-1:0]      inj_addr,
  input  logic [IW-1:0]      inj_bit,
  input  logic [AW-1:0]      rd_addr,
  output logic [WW-1:0]      rd_word
);
  import dcc_pkg::*;

  logic [WW-1:0] mem     [DEPTH];
  logic [WW-1:0] nxt     [DEPTH];
  logic [WW-1:0] st_word;
  logic [WW-1:0] flip_mask;

  assign flip_mask = {{(WW-1){1'b0}}, 1'b1} << inj_bit;

  for (genvar b = 0; b < BYTES; b++) begin : g_enc
    assign st_word[b*SLICE_W +: SLICE_W] =
      {even_par(st_data[b*8 +: 8]), st_data[b*8 +: 8]};
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_word
    always_comb begin
      nxt[e] = mem[e];
      if (st_en && st_addr == AW'(e)) begin
        for (int b = 0; b < BYTES; b++) begin
          if (st_be[b]) nxt[e][b*SLICE_W +: SLICE_W] = st_word[b*SLICE_W +: SLICE_W];
        end
      end
      if (fx_en && fx_addr == AW'(e)) nxt[e] = fx_word;
      if (inj_en && inj_addr == AW'(e)) nxt[e] = nxt[e] ^ flip_mask;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) mem[e] <= '0;
      else        mem[e] <= nxt[e];
    end
  end

  assign rd_word = mem[rd_addr];
endmodule

// File: rtl/dcc_ld_port.sv
module dcc_ld_port #(
  parameter int unsigned BYTES = 4,
  parameter int unsigned AW    = 4,
  parameter int unsigned WW    = BYTES * dcc_pkg::SLICE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic [AW-1:0]      req_addr,
  input  logic [WW-1:0]      cap_word,
  output logic               err_now,
  output logic               fix_q,
  output logic [AW-1:0]      hold_addr,
  output logic               rsp_valid,
  output logic [8*BYTES-1:0] rsp_data,
  output logic               rsp_uerr,
  output logic               corr_evt,
  output logic               fix_we,
  output logic [WW-1:0]      fix_word
);
  import dcc_pkg::*;

  logic             pend_q;
  logic [AW-1:0]    addr_q;
  logic [WW-1:0]    word_q;
  logic [BYTES-1:0] slice_bad;
  logic             bad;

  for (genvar b = 0; b < BYTES; b++) begin : g_chk
    assign slice_bad[b]         = ^word_q[b*SLICE_W +: SLICE_W];
    assign rsp_data[b*8 +: 8]   = word_q[b*SLICE_W +: 8];
  end

  assign bad       = |slice_bad;
  assign err_now   = pend_q && !fix_q && bad;
  assign rsp_valid = pend_q && (fix_q || !bad);
  assign rsp_uerr  = fix_q && bad;
  assign corr_evt  = fix_q && !bad;
  assign fix_we    = fix_q && !bad;
  assign fix_word  = word_q;
  assign hold_addr = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      fix_q  <= 1'b0;
      addr_q <= '0;
      word_q <= '0;
    end else if (err_now) begin
      pend_q <= 1'b1;
      fix_q  <= 1'b1;
      word_q <= cap_word;
    end else begin
      pend_q <= fire;
      fix_q  <= 1'b0;
      if (fire) begin
        addr_q <= req_addr;
        word_q <= cap_word;
      end
    end
  end
endmodule

// File: rtl/dual_copy_array.sv
module dual_copy_array #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned BYTES = 4,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter int unsigned IW    = $clog2(BYTES * dcc_pkg::SLICE_W)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           ld_valid,
  output logic [1:0]           ld_ready,
  input  logic [2*AW-1:0]      ld_addr,
  input  logic                 st_valid,
  output logic                 st_ready,
  input  logic [AW-1:0]        st_addr,
  input  logic [BYTES-1:0]     st_be,
  input  logic [8*BYTES-1:0]   st_data,
  input  logic                 inj_valid,
  input  logic                 inj_copy,
  input  logic [AW-1:0]        inj_addr,
  input  logic [IW-1:0]        inj_bit,
  output logic [1:0]           rsp_valid,
  output logic [2*8*BYTES-1:0] rsp_data,
  output logic [1:0]           rsp_uerr,
  output logic [1:0]           corr_evt
);
  localparam int unsigned WW = BYTES * dcc_pkg::SLICE_W;
  localparam int unsigned NP = 2;

  logic [NP-1:0] err_now, fix_q, fix_we;
  logic [AW-1:0] hold_addr [NP];
  logic [AW-1:0] rd_addr   [NP];
  logic [WW-1:0] rd_word   [NP];
  logic [WW-1:0] cap_word  [NP];
  logic [WW-1:0] fix_word  [NP];
  logic          busy, st_fire;

  assign busy     = |err_now || |fix_q;
  assign st_ready = !busy;
  assign st_fire  = st_valid && st_ready;
  assign ld_ready = {NP{!busy && !st_fire}};

  for (genvar p = 0; p < NP; p++) begin : g_side
    localparam int unsigned Q = NP - 1 - p;

    // A copy's read port is lent to the other side while that side re-reads.
    assign rd_addr[p]  = err_now[Q] ? hold_addr[Q] : ld_addr[p*AW +: AW];
    assign cap_word[p] = err_now[p] ? rd_word[Q] : rd_word[p];

    dcc_bank #(.DEPTH(DEPTH), .BYTES(BYTES), .AW(AW), .WW(WW), .IW(IW)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .st_en    (st_fire),
      .st_addr  (st_addr),
      .st_be    (st_be),
      .st_data  (st_data),
      .fx_en    (fix_we[p]),
      .fx_addr  (hold_addr[p]),
      .fx_word  (fix_word[p]),
      .inj_en   (inj_valid && (inj_copy == 1'(p))),
      .inj_addr (inj_addr),
      .inj_bit  (inj_bit),
      .rd_addr  (rd_addr[p]),
      .rd_word  (rd_word[p])
    );

    dcc_ld_port #(.BYTES(BYTES), .AW(AW), .WW(WW)) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (ld_valid[p] && ld_ready[p]),
      .req_addr  (ld_addr[p*AW +: AW]),
      .cap_word  (cap_word[p]),
      .err_now   (err_now[p]),
      .fix_q     (fix_q[p]),
      .hold_addr (hold_addr[p]),
      .rsp_valid (rsp_valid[p]),
      .rsp_data  (rsp_data[p*8*BYTES +: 8*BYTES]),
      .rsp_uerr  (rsp_uerr[p]),
      .corr_evt  (corr_evt[p]),
      .fix_we    (fix_we[p]),
      .fix_word  (fix_word[p])
    );
  end
endmodule

// File: rtl/dcc_checker.sv
module dcc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] ld_valid,
  input logic [1:0] ld_ready,
  input logic       st_valid,
  input logic       st_ready,
  input logic [1:0] rsp_valid,
  input logic [1:0] rsp_uerr,
  input logic [1:0] corr_evt
);
  p_store_blocks_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready) |-> (ld_ready == 2'b00));

  for (genvar p = 0; p < 2; p++) begin : g_p
    p_withheld_then_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((ld_valid[p] && ld_ready[p]) ##1 !rsp_valid[p]) |=> rsp_valid[p]);

    p_detect_cycle_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((ld_valid[p] && ld_ready[p]) ##1 !rsp_valid[p]) |-> (!st_ready && ld_ready == 2'b00));

    p_corr_with_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
      corr_evt[p] |-> rsp_valid[p]);

    p_uerr_not_corr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_uerr[p] |-> (rsp_valid[p] && !corr_evt[p]));
  end
endmodule

bind dual_copy_array dcc_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ld_valid  (ld_valid),
  .ld_ready  (ld_ready),
  .st_valid  (st_valid),
  .st_ready  (st_ready),
  .rsp_valid (rsp_valid),
  .rsp_uerr  (rsp_uerr),
  .corr_evt  (corr_evt)
);

// File: tb/dual_copy_array_tb.sv
module dual_copy_array_tb;
  localparam int AW = 4;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ld_valid = '0;
  logic [1:0]  ld_ready;
  logic [7:0]  ld_addr = '0;
  logic        st_valid = 1'b0;
  logic        st_ready;
  logic [3:0]  st_addr = '0;
  logic [3:0]  st_be = '0;
  logic [31:0] st_data = '0;
  logic        inj_valid = 1'b0;
  logic        inj_copy = 1'b0;
  logic [3:0]  inj_addr = '0;
  logic [5:0]  inj_bit = '0;
  logic [1:0]  rsp_valid;
  logic [63:0] rsp_data;
  logic [1:0]  rsp_uerr;
  logic [1:0]  corr_evt;

  always #4 clk = ~clk;  // 125 MHz

  dual_copy_array u_dut (.*);

  int total = 0, fails = 0;
  bit done = 1'b0;
  string tag = "R1";

  // reference state
  logic [35:0] m [2][DEPTH];
  int          pend [2];   // 0 idle, 1 normal read, 2 repair read
  logic [3:0]  paddr [2];
  logic [35:0] pword [2];

  function automatic bit is_bad(input logic [35:0] w);
    for (int b = 0; b < 4; b++) if (^w[b*9 +: 9]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] dat(input logic [35:0] w);
    logic [31:0] d;
    for (int b = 0; b < 4; b++) d[b*8 +: 8] = w[b*9 +: 8];
    return d;
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc();
    bit err [2];
    bit busy, e_st_ready, e_ld_ready, st_f;
    bit ld_f [2];
    #2;
    busy = 1'b0;
    for (int p = 0; p < 2; p++) begin
      err[p] = (pend[p] == 1) && is_bad(pword[p]);
      if (err[p] || pend[p] == 2) busy = 1'b1;
    end
    e_st_ready = !busy;
    st_f       = st_valid && e_st_ready;
    e_ld_ready = !busy && !st_f;
    chk(st_ready == e_st_ready, "st_ready (R7)", 32'(st_ready), 32'(e_st_ready));
    chk(ld_ready == {2{e_ld_ready}}, "ld_ready (R4/R7)", 32'(ld_ready), 32'({2{e_ld_ready}}));
    for (int p = 0; p < 2; p++) begin
      bit ev, eu, ec;
      ev = (pend[p] == 2) || (pend[p] == 1 && !is_bad(pword[p]));
      eu = (pend[p] == 2) && is_bad(pword[p]);
      ec = (pend[p] == 2) && !is_bad(pword[p]);
      ld_f[p] = ld_valid[p] && e_ld_ready;
      chk(rsp_valid[p] == ev, $sformatf("rsp_valid[%0d] (R2/R5)", p), 32'(rsp_valid[p]), 32'(ev));
      chk(rsp_uerr[p] == eu, $sformatf("rsp_uerr[%0d] (R8)", p), 32'(rsp_uerr[p]), 32'(eu));
      chk(corr_evt[p] == ec, $sformatf("corr_evt[%0d] (R5)", p), 32'(corr_evt[p]), 32'(ec));
      if (ev && !eu)
        chk(rsp_data[p*32 +: 32] == dat(pword[p]), $sformatf("rsp_data[%0d] (R2/R3)", p),
            rsp_data[p*32 +: 32], dat(pword[p]));
    end
    @(posedge clk);
    begin
      logic [35:0] old [2][DEPTH];
      bit fixw [2];
      old = m;
      for (int p = 0; p < 2; p++) begin
        fixw[p] = (pend[p] == 2) && !is_bad(pword[p]);
        if (fixw[p]) m[p][paddr[p]] = pword[p];
      end
      for (int p = 0; p < 2; p++) begin
        if (err[p]) begin
          pend[p]  = 2;
          pword[p] = old[1-p][paddr[p]];
        end else if (ld_f[p]) begin
          pend[p]  = 1;
          paddr[p] = ld_addr[p*AW +: AW];
          pword[p] = old[p][paddr[p]];
        end else pend[p] = 0;
      end
      if (st_f)
        for (int c = 0; c < 2; c++)
          for (int b = 0; b < 4; b++)
            if (st_be[b]) m[c][st_addr][b*9 +: 9] = {^st_data[b*8 +: 8], st_data[b*8 +: 8]};
      if (inj_valid) m[inj_copy][inj_addr][inj_bit] = ~m[inj_copy][inj_addr][inj_bit];
    end
    @(negedge clk);
    ld_valid = '0; st_valid = 1'b0; inj_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic store(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
    st_valid = 1'b1; st_addr = a; st_data = d; st_be = be;
  endtask

  task automatic load(input logic [1:0] v, input logic [3:0] a0, input logic [3:0] a1);
    ld_valid = v; ld_addr = {a1, a0};
  endtask

  task automatic flip(input bit c, input logic [3:0] a, input logic [5:0] b);
    inj_valid = 1'b1; inj_copy = c; inj_addr = a; inj_bit = b;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired act=0 exp=1");
      summary();
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 2; c++) for (int a = 0; a < DEPTH; a++) m[c][a] = '0;
    for (int p = 0; p < 2; p++) begin pend[p] = 0; paddr[p] = '0; pword[p] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    tag = "R1";  // reset state and zero contents
    idle(1);
    load(2'b11, 4'd3, 4'd9); cyc(); idle(1);

    tag = "R3";
    store(4'd1, 32'h11223344, 4'hF); cyc();
    store(4'd2, 32'hA5A5A5A5, 4'hF); cyc();
    tag = "R4";  // loads offered with a store
    store(4'd2, 32'hFFFFFFFF, 4'b0101); load(2'b11, 4'd1, 4'd2); cyc();
    store(4'd3, 32'h0BADF00D, 4'hF); cyc();

    tag = "R2";
    load(2'b11, 4'd1, 4'd2); cyc();
    load(2'b11, 4'd2, 4'd1); cyc();
    load(2'b01, 4'd3, 4'd0); cyc(); idle(1);

    tag = "R5";
    flip(1'b0, 4'd2, 6'd5); cyc();
    load(2'b11, 4'd2, 4'd1); cyc();
    tag = "R7";  // stores and loads offered during detection and repair
    store(4'd5, 32'hCAFEBABE, 4'hF); load(2'b11, 4'd5, 4'd5); cyc();
    store(4'd5, 32'hCAFEBABE, 4'hF); load(2'b11, 4'd5, 4'd5); cyc();
    idle(1);

    tag = "R6";
    load(2'b01, 4'd2, 4'd0); cyc(); idle(1);

    tag = "R9";  // parity bit only
    flip(1'b1, 4'd1, 6'd8); cyc();
    load(2'b10, 4'd0, 4'd1); cyc(); idle(3);
    load(2'b10, 4'd0, 4'd1); cyc(); idle(1);

    tag = "R8";
    flip(1'b0, 4'd3, 6'd0); cyc();
    flip(1'b1, 4'd3, 6'd17); cyc();
    load(2'b01, 4'd3, 4'd0); cyc(); idle(3);
    load(2'b10, 4'd0, 4'd3); cyc(); idle(3);

    tag = "R10";
    store(4'd4, 32'h01234567, 4'hF); cyc();
    store(4'd6, 32'h89ABCDEF, 4'hF); cyc();
    flip(1'b0, 4'd4, 6'd30); cyc();
    flip(1'b1, 4'd6, 6'd12); cyc();
    load(2'b11, 4'd4, 4'd6); cyc(); idle(3);
    load(2'b11, 4'd4, 4'd6); cyc(); idle(1);

    tag = "R2";  // mixed traffic
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0)
        store(4'($urandom_range(0, 15)), $urandom, 4'($urandom_range(0, 15)));
      load(2'($urandom_range(0, 3)), 4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)));
      if ($urandom_range(0, 15) == 0)
        flip(1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)), 6'($urandom_range(0, 35)));
      cyc();
    end
    idle(4);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule